// File: doc/BRIEF.md
# Scrambling Mode Change Scheduler

This block turns two 4-bit front-panel mode selectors into the live scrambling state of a video channel. One selector governs how strongly the sync pulses are suppressed (clear, 6 dB or 10 dB). The other governs whether the active video is inverted. Each selector code names a policy. A policy is either a clear or fixed state, or a state that is re-chosen on a timed schedule. A timed schedule counts either video fields or seconds, and in its dynamic modes draws the new state from a pseudo-random sequence.

The block sees a one-cycle field-start strobe and a one-cycle one-second tick. Every output change is aligned to a field start, so the suppression level and inversion state never change partway through a field. A new selector code restarts that channel's schedule. The new policy takes effect at the next field start.

Top module: `scr_sched`

## Requirements
- R1: While reset is asserted and after it is released, before any field start, `sync_level_o` is 0 and `video_inv_o` is 0.
- R2: `sync_level_o` encodes 0 = clear, 1 = 6 dB, 2 = 10 dB. The value 3 never appears.
- R3: Both outputs change only on the clock edge at which `field_start_i` is high. Neither a selector change nor a second tick alters them at any other edge.
- R4: Sync codes 0, 9, A, B, C, D, E and F give level 0. Sync code 1 gives level 1 and sync code 2 gives level 2. Video codes 0 and 8 through F give no inversion, and video code 1 gives constant inversion. A code must be held for at least one clock before the field start that applies it.
- R5: A selector code that differs from the one held on the previous clock clears that channel's interval counter and pending change. It also restarts the timed state at 6 dB (sync) or inverted (video). Outputs keep their old value until the next field start.
- R6: Sync code 3 and video code 2 are field scene modes. Counting field starts since the code was applied, the state alternates every FIELD_STEP field starts: sync between 6 dB and 10 dB, video between inverted and not inverted. Second ticks are ignored in these modes.
- R7: Sync code 4 and video code 3 are second scene modes. After every SCENE_SECS second ticks a change becomes pending, and it is applied at the next field start. A field start in the same cycle as the completing tick applies it at once. Field starts alone never advance the state in these modes.
- R8: Sync codes 5, 6, 7 and video codes 4, 5, 6 are dynamic modes. Their second-based periods are DYN_SHORT, DYN_MID and DYN_LONG, with the same pending rule as R7. Each channel keeps a 16-bit LFSR with its own seed. It shifts left with new bit 0 = bit15 ^ bit13 ^ bit12 ^ bit10, once per applied change, and is not reset by a selector change. The new sync level comes from the new LFSR bits [1:0]: 0 gives clear, 1 gives 6 dB, and 2 or 3 give 10 dB. The new video inversion equals the new LFSR bit 0.
- R9: Sync code 8 and video code 7 are linear test modes that step every FIELD_STEP field starts. Sync follows 6 dB, 10 dB, clear and back to 6 dB. Video alternates, starting from inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_sel_i | input | 4 | Sync suppression mode selector |
| video_sel_i | input | 4 | Video inversion mode selector |
| field_start_i | input | 1 | One-cycle strobe at the start of each video field |
| sec_tick_i | input | 1 | One-cycle strobe once per second |
| sync_level_o | output | 2 | Current sync suppression level |
| video_inv_o | output | 1 | Current video inversion enable |

## Verification
The bench builds the block with FIELD_STEP = 4, SCENE_SECS = 3, DYN_SHORT = 2, DYN_MID = 3 and DYN_LONG = 5. With these values several full field schedules and several dynamic LFSR steps fit into a few hundred clocks. The short periods bring within reach the wrap of each counter and the three-step linear sync cycle. They also cover a pending change that is held across field starts with no tick, a tick that coincides with a field start, and a selector bounce in the middle of an interval.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int INTV_W = 16;
    localparam int LFSR_W = 16;

    typedef logic [1:0] level_t;

    localparam level_t LVL_CLEAR = 2'd0;
    localparam level_t LVL_6DB   = 2'd1;
    localparam level_t LVL_10DB  = 2'd2;

    typedef enum logic [2:0] {
        POL_CLEAR,
        POL_FIXED,
        POL_SCENE,
        POL_DYN,
        POL_LINEAR
    } pol_kind_e;

    typedef struct packed {
        pol_kind_e         kind;
        level_t            fixed_val;
        logic              by_sec;
        logic [INTV_W-1:0] interval;
    } policy_t;

    typedef struct packed {
        logic [3:0]        sel;
        logic [INTV_W-1:0] cnt;
        logic              due;
        level_t            state;
        logic [LFSR_W-1:0] lfsr;
        level_t            out;
    } chan_t;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] v);
        return {v[LFSR_W-2:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic level_t policy_target(input policy_t p, input level_t s);
        case (p.kind)
            POL_CLEAR: return LVL_CLEAR;
            POL_FIXED: return p.fixed_val;
            default:   return s;
        endcase
    endfunction

endpackage

// File: rtl/scr_policy_decode.sv
module scr_policy_decode
    import scr_pkg::*;
#(
    parameter bit IS_SYNC    = 1'b1,
    parameter int FIELD_STEP = 16,
    parameter int SCENE_SECS = 3,
    parameter int DYN_SHORT  = 15,
    parameter int DYN_MID    = 30,
    parameter int DYN_LONG   = 60
) (
    input  logic [3:0] sel_i,
    output policy_t    pol_o
);

    localparam logic [INTV_W-1:0] FS_I = INTV_W'(FIELD_STEP);
    localparam logic [INTV_W-1:0] SC_I = INTV_W'(SCENE_SECS);
    localparam logic [INTV_W-1:0] DS_I = INTV_W'(DYN_SHORT);
    localparam logic [INTV_W-1:0] DM_I = INTV_W'(DYN_MID);
    localparam logic [INTV_W-1:0] DL_I = INTV_W'(DYN_LONG);

    generate
        if (IS_SYNC) begin : g_sync
            always_comb begin
                pol_o = '{kind: POL_CLEAR, fixed_val: LVL_CLEAR, by_sec: 1'b0, interval: FS_I};
                case (sel_i)
                    4'h1: begin pol_o.kind = POL_FIXED; pol_o.fixed_val = LVL_6DB; end
                    4'h2: begin pol_o.kind = POL_FIXED; pol_o.fixed_val = LVL_10DB; end
                    4'h3: pol_o.kind = POL_SCENE;
                    4'h4: begin pol_o.kind = POL_SCENE; pol_o.by_sec = 1'b1; pol_o.interval = SC_I; end
                    4'h5: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DS_I; end
                    4'h6: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DM_I; end
                    4'h7: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DL_I; end
                    4'h8: pol_o.kind = POL_LINEAR;
                    default: ;
                endcase
            end
        end else begin : g_video
            always_comb begin
                pol_o = '{kind: POL_CLEAR, fixed_val: LVL_CLEAR, by_sec: 1'b0, interval: FS_I};
                case (sel_i)
                    4'h1: begin pol_o.kind = POL_FIXED; pol_o.fixed_val = 2'd1; end
                    4'h2: pol_o.kind = POL_SCENE;
                    4'h3: begin pol_o.kind = POL_SCENE; pol_o.by_sec = 1'b1; pol_o.interval = SC_I; end
                    4'h4: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DS_I; end
                    4'h5: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DM_I; end
                    4'h6: begin pol_o.kind = POL_DYN; pol_o.by_sec = 1'b1; pol_o.interval = DL_I; end
                    4'h7: pol_o.kind = POL_LINEAR;
                    default: ;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/scr_state_step.sv
module scr_state_step
    import scr_pkg::*;
#(
    parameter bit IS_SYNC = 1'b1
) (
    input  pol_kind_e         kind_i,
    input  level_t            state_i,
    input  logic [LFSR_W-1:0] lfsr_nxt_i,
    output level_t            state_o
);

    generate
        if (IS_SYNC) begin : g_sync
            always_comb begin
                state_o = state_i;
                case (kind_i)
                    POL_SCENE:  state_o = (state_i == LVL_6DB) ? LVL_10DB : LVL_6DB;
                    POL_LINEAR: state_o = (state_i == LVL_10DB) ? LVL_CLEAR : state_i + 2'd1;
                    POL_DYN: begin
                        case (lfsr_nxt_i[1:0])
                            2'd0:    state_o = LVL_CLEAR;
                            2'd1:    state_o = LVL_6DB;
                            default: state_o = LVL_10DB;
                        endcase
                    end
                    default: ;
                endcase
            end
        end else begin : g_video
            always_comb begin
                state_o = state_i;
                case (kind_i)
                    POL_SCENE, POL_LINEAR: state_o = {1'b0, ~state_i[0]};
                    POL_DYN:               state_o = {1'b0, lfsr_nxt_i[0]};
                    default: ;
                endcase
            end
        end
    endgenerate

endmodule

// File: rtl/scr_channel.sv
module scr_channel
    import scr_pkg::*;
#(
    parameter bit              IS_SYNC    = 1'b1,
    parameter int              OUT_W      = 2,
    parameter int              FIELD_STEP = 16,
    parameter int              SCENE_SECS = 3,
    parameter int              DYN_SHORT  = 15,
    parameter int              DYN_MID    = 30,
    parameter int              DYN_LONG   = 60,
    parameter logic [LFSR_W-1:0] SEED     = 16'hACE1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [3:0]       sel_i,
    input  logic             field_start_i,
    input  logic             sec_tick_i,
    output logic [OUT_W-1:0] out_o
);

    localparam level_t START = LVL_6DB;
    localparam chan_t  RST   = '{sel: 4'h0, cnt: '0, due: 1'b0, state: START,
                                 lfsr: SEED, out: LVL_CLEAR};

    chan_t             q, d;
    policy_t           pol;
    level_t            state_nxt;
    logic [LFSR_W-1:0] lfsr_nxt;
    logic              timed, ev, wrap, advance;

    scr_policy_decode #(
        .IS_SYNC    (IS_SYNC),
        .FIELD_STEP (FIELD_STEP),
        .SCENE_SECS (SCENE_SECS),
        .DYN_SHORT  (DYN_SHORT),
        .DYN_MID    (DYN_MID),
        .DYN_LONG   (DYN_LONG)
    ) u_decode (
        .sel_i (q.sel),
        .pol_o (pol)
    );

    assign lfsr_nxt = lfsr_step(q.lfsr);

    scr_state_step #(.IS_SYNC(IS_SYNC)) u_step (
        .kind_i     (pol.kind),
        .state_i    (q.state),
        .lfsr_nxt_i (lfsr_nxt),
        .state_o    (state_nxt)
    );

    always_comb begin
        d       = q;
        d.sel   = sel_i;
        timed   = (pol.kind == POL_SCENE) || (pol.kind == POL_DYN) || (pol.kind == POL_LINEAR);
        ev      = pol.by_sec ? sec_tick_i : field_start_i;
        wrap    = timed && ev && (q.cnt == pol.interval - 1'b1);
        advance = 1'b0;
        if (sel_i != q.sel) begin
            d.cnt   = '0;
            d.due   = 1'b0;
            d.state = START;
        end else begin
            if (timed && ev) begin
                d.cnt = wrap ? '0 : q.cnt + 1'b1;
            end
            advance = timed && field_start_i && (q.due || wrap);
            if (advance) begin
                d.due   = 1'b0;
                d.state = state_nxt;
                if (pol.kind == POL_DYN) begin
                    d.lfsr = lfsr_nxt;
                end
            end else if (wrap) begin
                d.due = 1'b1;
            end
        end
        if (field_start_i) begin
            d.out = policy_target(pol, d.state);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            q <= RST;
        end else begin
            q <= d;
        end
    end

    assign out_o = q.out[OUT_W-1:0];

endmodule

// File: rtl/scr_sched.sv
module scr_sched #(
    parameter int          FIELD_STEP = 16,
    parameter int          SCENE_SECS = 3,
    parameter int          DYN_SHORT  = 15,
    parameter int          DYN_MID    = 30,
    parameter int          DYN_LONG   = 60,
    parameter logic [15:0] SYNC_SEED  = 16'hACE1,
    parameter logic [15:0] VIDEO_SEED = 16'h5A5A
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic [3:0] sync_sel_i,
    input  logic [3:0] video_sel_i,
    input  logic       field_start_i,
    input  logic       sec_tick_i,
    output logic [1:0] sync_level_o,
    output logic       video_inv_o
);

    scr_channel #(
        .IS_SYNC    (1'b1),
        .OUT_W      (2),
        .FIELD_STEP (FIELD_STEP),
        .SCENE_SECS (SCENE_SECS),
        .DYN_SHORT  (DYN_SHORT),
        .DYN_MID    (DYN_MID),
        .DYN_LONG   (DYN_LONG),
        .SEED       (SYNC_SEED)
    ) u_sync (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sel_i         (sync_sel_i),
        .field_start_i (field_start_i),
        .sec_tick_i    (sec_tick_i),
        .out_o         (sync_level_o)
    );

    scr_channel #(
        .IS_SYNC    (1'b0),
        .OUT_W      (1),
        .FIELD_STEP (FIELD_STEP),
        .SCENE_SECS (SCENE_SECS),
        .DYN_SHORT  (DYN_SHORT),
        .DYN_MID    (DYN_MID),
        .DYN_LONG   (DYN_LONG),
        .SEED       (VIDEO_SEED)
    ) u_video (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .sel_i         (video_sel_i),
        .field_start_i (field_start_i),
        .sec_tick_i    (sec_tick_i),
        .out_o         (video_inv_o)
    );

endmodule

// File: rtl/scr_sched_chk.sv
module scr_sched_chk (
    input logic       clk_i,
    input logic       rst_ni,
    input logic [3:0] sync_sel_i,
    input logic [3:0] video_sel_i,
    input logic       field_start_i,
    input logic       sec_tick_i,
    input logic [1:0] sync_level_o,
    input logic       video_inv_o
);

    function automatic logic sync_is_clear(input logic [3:0] c);
        return (c == 4'h0) || (c >= 4'h9);
    endfunction

    function automatic logic video_is_clear(input logic [3:0] c);
        return (c == 4'h0) || (c >= 4'h8);
    endfunction

    logic unused_tick;
    assign unused_tick = sec_tick_i;

    assert_sync_legal_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sync_level_o != 2'd3);

    assert_hold_between_fields_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$past(field_start_i) |-> ($stable(sync_level_o) && $stable(video_inv_o)));

    assert_sync_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 2) && $past(field_start_i) && ($past(sync_sel_i) == $past(sync_sel_i, 2))
         && sync_is_clear($past(sync_sel_i))) |-> (sync_level_o == 2'd0));

    assert_sync_fixed6_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 2) && $past(field_start_i) && ($past(sync_sel_i) == 4'h1)
         && ($past(sync_sel_i, 2) == 4'h1)) |-> (sync_level_o == 2'd1));

    assert_sync_fixed10_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 2) && $past(field_start_i) && ($past(sync_sel_i) == 4'h2)
         && ($past(sync_sel_i, 2) == 4'h2)) |-> (sync_level_o == 2'd2));

    assert_video_clear_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 2) && $past(field_start_i) && ($past(video_sel_i) == $past(video_sel_i, 2))
         && video_is_clear($past(video_sel_i))) |-> !video_inv_o);

    assert_video_const_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(rst_ni, 2) && $past(field_start_i) && ($past(video_sel_i) == 4'h1)
         && ($past(video_sel_i, 2) == 4'h1)) |-> video_inv_o);

endmodule

bind scr_sched scr_sched_chk u_chk (.*);

// File: tb/scr_sched_tb_top.sv
`timescale 1ns/1ps
module scr_sched_tb_top;

    localparam int          FS   = 4;
    localparam int          SC   = 3;
    localparam int          DS   = 2;
    localparam int          DM   = 3;
    localparam int          DL   = 5;
    localparam logic [15:0] SSEED = 16'hACE1;
    localparam logic [15:0] VSEED = 16'h5A5A;

    // {sync_sel, video_sel, expected sync level, expected inversion} after one field start
    localparam logic [10:0] VEC [0:15] = '{
        {4'h0, 4'h0, 2'd0, 1'b0}, {4'h1, 4'h1, 2'd1, 1'b1},
        {4'h2, 4'h2, 2'd2, 1'b1}, {4'h3, 4'h3, 2'd1, 1'b1},
        {4'h4, 4'h4, 2'd1, 1'b1}, {4'h5, 4'h5, 2'd1, 1'b1},
        {4'h6, 4'h6, 2'd1, 1'b1}, {4'h7, 4'h7, 2'd1, 1'b1},
        {4'h8, 4'h8, 2'd1, 1'b0}, {4'h9, 4'h9, 2'd0, 1'b0},
        {4'hA, 4'hA, 2'd0, 1'b0}, {4'hB, 4'hB, 2'd0, 1'b0},
        {4'hC, 4'hC, 2'd0, 1'b0}, {4'hD, 4'hD, 2'd0, 1'b0},
        {4'hE, 4'hE, 2'd0, 1'b0}, {4'hF, 4'hF, 2'd0, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ssel = 4'h0, vsel = 4'h0;
    logic       fs = 1'b0, tick = 1'b0;
    logic [1:0] slvl;
    logic       vinv;
    int         checks = 0, failures = 0;
    bit         done = 1'b0;
    logic [15:0] ms, mv;

    always #2.5 clk = ~clk;

    scr_sched #(
        .FIELD_STEP (FS), .SCENE_SECS (SC), .DYN_SHORT (DS), .DYN_MID (DM), .DYN_LONG (DL),
        .SYNC_SEED (SSEED), .VIDEO_SEED (VSEED)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .sync_sel_i (ssel), .video_sel_i (vsel),
        .field_start_i (fs), .sec_tick_i (tick), .sync_level_o (slvl), .video_inv_o (vinv)
    );

    function automatic logic [15:0] m_step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    function automatic logic [1:0] m_map(input logic [1:0] b);
        return (b == 2'd0) ? 2'd0 : (b == 2'd1) ? 2'd1 : 2'd2;
    endfunction

    task automatic chk(input string req, input logic [1:0] es, input logic ev);
        checks++;
        if (slvl !== es || vinv !== ev) begin
            failures++;
            $display("FAIL %s: sync=%0d inv=%0d expected sync=%0d inv=%0d", req, slvl, vinv, es, ev);
        end
    endtask

    task automatic clocks(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic field();
        @(negedge clk) fs = 1'b1;
        @(negedge clk) fs = 1'b0;
    endtask

    task automatic sec();
        @(negedge clk) tick = 1'b1;
        @(negedge clk) tick = 1'b0;
    endtask

    task automatic field_and_sec();
        @(negedge clk) begin fs = 1'b1; tick = 1'b1; end
        @(negedge clk) begin fs = 1'b0; tick = 1'b0; end
    endtask

    task automatic set_sel(input logic [3:0] s, input logic [3:0] v);
        @(negedge clk) begin ssel = s; vsel = v; end
        clocks(2);
    endtask

    task automatic do_reset();
        @(negedge clk) begin rst_n = 1'b0; ssel = 4'h0; vsel = 4'h0; fs = 1'b0; tick = 1'b0; end
        clocks(3);
        chk("R1 in reset", 2'd0, 1'b0);
        @(negedge clk) rst_n = 1'b1;
        clocks(2);
        chk("R1 after reset", 2'd0, 1'b0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [1:0] ps;
        logic       pv;
        do_reset();

        // Table walk: every code of both selectors, one field start each (R4, R2, R5)
        ps = 2'd0; pv = 1'b0;
        for (int i = 0; i < 16; i++) begin
            set_sel(VEC[i][10:7], VEC[i][6:3]);
            chk("R5 held before field start", ps, pv);
            field();
            chk("R4 code table", VEC[i][2:1], VEC[i][0]);
            ps = VEC[i][2:1]; pv = VEC[i][0];
        end

        // R6: field scene modes, second ticks ignored
        set_sel(4'h3, 4'h2);
        for (int k = 1; k <= 2 * FS; k++) begin
            sec();
            field();
            if (k == 1 || k == FS - 1) chk("R6 scene field first interval", 2'd1, 1'b1);
            if (k == FS || k == 2 * FS - 1) chk("R6 scene field second interval", 2'd2, 1'b0);
            if (k == 2 * FS) chk("R6 scene field back", 2'd1, 1'b1);
        end

        // R9: linear test modes
        set_sel(4'h8, 4'h7);
        for (int k = 1; k <= 3 * FS; k++) begin
            field();
            if (k == FS - 1) chk("R9 linear start", 2'd1, 1'b1);
            if (k == FS) chk("R9 linear step 1", 2'd2, 1'b0);
            if (k == 2 * FS) chk("R9 linear step 2", 2'd0, 1'b1);
            if (k == 3 * FS) chk("R9 linear wrap", 2'd1, 1'b0);
        end

        // R7: second scene modes
        set_sel(4'h4, 4'h3);
        field();
        chk("R7 scene sec start", 2'd1, 1'b1);
        for (int k = 0; k < SC; k++) sec();
        clocks(2);
        chk("R3 pending change waits for field start", 2'd1, 1'b1);
        field();
        chk("R7 pending applied at field start", 2'd2, 1'b0);
        field();
        chk("R7 field start alone does not advance", 2'd2, 1'b0);
        for (int k = 0; k < SC - 1; k++) sec();
        field_and_sec();
        chk("R7 coincident tick and field start", 2'd1, 1'b1);
        for (int k = 0; k < 2 * FS + 1; k++) field();
        chk("R7 field starts not counted", 2'd1, 1'b1);

        // R5: selector bounce clears the interval counter
        set_sel(4'h3, 4'h2);
        for (int k = 0; k < FS - 1; k++) field();
        chk("R5 before bounce", 2'd1, 1'b1);
        set_sel(4'h4, 4'h3);
        set_sel(4'h3, 4'h2);
        chk("R5 bounce leaves outputs", 2'd1, 1'b1);
        for (int k = 0; k < FS - 1; k++) field();
        chk("R5 counter restarted", 2'd1, 1'b1);
        field();
        chk("R5 full interval after restart", 2'd2, 1'b0);

        // R8: dynamic modes from a fresh reset
        do_reset();
        ms = SSEED; mv = VSEED;
        set_sel(4'h5, 4'h4);
        field();
        chk("R8 dynamic start", 2'd1, 1'b1);
        for (int n = 0; n < 6; n++) begin
            for (int k = 0; k < DS; k++) sec();
            field();
            ms = m_step(ms); mv = m_step(mv);
            chk("R8 dynamic short step", m_map(ms[1:0]), mv[0]);
        end
        set_sel(4'h7, 4'h6);
        field();
        chk("R8 dynamic restart state", 2'd1, 1'b1);
        for (int k = 0; k < DL - 1; k++) sec();
        field();
        chk("R8 long period not reached", 2'd1, 1'b1);
        sec();
        field();
        ms = m_step(ms); mv = m_step(mv);
        chk("R8 dynamic long step", m_map(ms[1:0]), mv[0]);
        set_sel(4'h6, 4'h5);
        field();
        for (int k = 0; k < DM; k++) sec();
        field();
        ms = m_step(ms); mv = m_step(mv);
        chk("R8 dynamic mid step", m_map(ms[1:0]), mv[0]);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule